// File: doc/BRIEF.md
# Twisted-Ring Counter with One-Hot Phase Decoder

This block is an n-bit twisted-ring (switch-tail) counter. It is built as a right shift register that feeds the inverted value of its least significant bit back into its most significant bit. Starting from all zeros, the register first fills with ones from the left and then empties them from the left. It passes through 2n distinct patterns before it comes back to zero.

A decoder next to the register turns the current pattern into a 2n-wide one-hot phase vector. The n-bit patterns that the sequence never visits are treated as don't-cares, so each output bit is the AND of only two register bits. This makes the block a cheap, glitch-tolerant phase generator for sequencing timing strobes.

A synchronous reset clears the ring and an enable gates the stepping. A build-time option lets an enabled step out of any illegal pattern land on all zeros, so the counter rejoins the legal cycle.

Top module: `twisted_ring_counter`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the ring is cleared to all zeros and `phase_o` equals 1 (only bit 0 set). Reset takes priority over `en_i`.
- R2: When `en_i` is high and reset is low at a rising edge, `ring_o` becomes `{~ring_o[0], ring_o[WIDTH-1:1]}`: every bit moves one place toward bit 0, and the inverse of the old bit 0 enters bit WIDTH-1.
- R3: When `en_i` is low and reset is low, `ring_o` keeps its value across the edge.
- R4: After reset, exactly 2*WIDTH enabled steps bring the ring back to all zeros, and no earlier step does. For WIDTH=4 the sequence is 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001.
- R5: `phase_o` has exactly one bit set in every reachable state. Bit k is set when the ring holds the pattern reached k enabled steps after all zeros (k from 0 to 2*WIDTH-1).
- R6: The ring only ever holds legal patterns. A legal pattern has at most one position where two neighbouring bits differ.
- R7: `phase_o[WIDTH]` is set exactly when the ring is all ones, and `phase_o[0]` is set exactly when the ring is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Step enable |
| ring_o | output | WIDTH | Current shift-register contents |
| phase_o | output | 2*WIDTH | One-hot phase decode of the ring |

## Verification
A corrupted ring register shows up on `phase_o` in the same cycle. Because every decode term looks at only two bits, an illegal pattern can light zero or several phase bits at once. The same corruption also breaks the shift relation on `ring_o` at the next enabled edge. A fault in the feedback inversion shows up within 2*WIDTH steps as a cycle of the wrong length, or as a ring that sticks at all zeros or all ones. A fault in the hold path shows up on the first cycle with the enable low.

// File: rtl/trc_pkg.sv
package trc_pkg;
    // Policy applied when an enabled step starts from an illegal ring pattern
    typedef enum logic {
        FIX_NONE    = 1'b0,
        FIX_TO_ZERO = 1'b1
    } trc_fix_e;

    localparam int unsigned TRC_MIN_WIDTH = 2;
endpackage

// File: rtl/trc_legal.sv
module trc_legal #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] ring_i,
    output logic             legal_o
);
    localparam int unsigned NEDGE = WIDTH - 1;

    logic [NEDGE-1:0] edge_w;

    // One flag per pair of neighbouring bits that differ
    for (genvar i = 0; i < NEDGE; i++) begin : g_edge
        assign edge_w[i] = ring_i[i] ^ ring_i[i+1];
    end

    assign legal_o = ($countones(edge_w) <= 1);
endmodule

// File: rtl/trc_decode.sv
module trc_decode #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0]   ring_i,
    output logic [2*WIDTH-1:0] phase_o
);
    // Empty ring and full ring are told apart by the two end bits
    assign phase_o[0]     = ~ring_i[WIDTH-1] & ~ring_i[0];
    assign phase_o[WIDTH] =  ring_i[WIDTH-1] &  ring_i[0];

    // Filling phase k: the 1/0 boundary sits between bits WIDTH-k and WIDTH-1-k
    // Emptying phase WIDTH+k: the 0/1 boundary sits at the same spot
    for (genvar k = 1; k < WIDTH; k++) begin : g_term
        assign phase_o[k]       =  ring_i[WIDTH-k] & ~ring_i[WIDTH-1-k];
        assign phase_o[WIDTH+k] = ~ring_i[WIDTH-k] &  ring_i[WIDTH-1-k];
    end
endmodule

// File: rtl/twisted_ring_counter.sv
module twisted_ring_counter
    import trc_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter trc_fix_e    FIX   = FIX_TO_ZERO
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    output logic [WIDTH-1:0]   ring_o,
    output logic [2*WIDTH-1:0] phase_o
);
    localparam int unsigned NPHASE = 2 * WIDTH;

    typedef struct packed {
        logic [WIDTH-1:0] ring;
    } trc_state_t;

    trc_state_t state_d, state_q;
    logic       legal_w;

    trc_legal #(.WIDTH(WIDTH)) u_legal (
        .ring_i  (state_q.ring),
        .legal_o (legal_w)
    );

    trc_decode #(.WIDTH(WIDTH)) u_decode (
        .ring_i  (state_q.ring),
        .phase_o (phase_o)
    );

    always_comb begin
        state_d = state_q;
        if (en_i) begin
            if (FIX == FIX_TO_ZERO && !legal_w) begin
                state_d.ring = '0;
            end else begin
                state_d.ring = {~state_q.ring[0], state_q.ring[WIDTH-1:1]};
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ring_o = state_q.ring;

    logic [$clog2(NPHASE+1)-1:0] unused_w;
    assign unused_w = NPHASE[$clog2(NPHASE+1)-1:0];
endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
    parameter int unsigned WIDTH = 4
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               en_i,
    input logic [WIDTH-1:0]   ring_o,
    input logic [2*WIDTH-1:0] phase_o
);
    logic [WIDTH-2:0] diff_w;
    for (genvar i = 0; i < WIDTH - 1; i++) begin : g_diff
        assign diff_w[i] = ring_o[i] ^ ring_o[i+1];
    end

    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (ring_o == '0 && phase_o == {{(2*WIDTH-1){1'b0}}, 1'b1}));

    p_step_shift_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> ring_o == {~$past(ring_o[0]), $past(ring_o[WIDTH-1:1])});

    p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(ring_o));

    p_single_phase_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(phase_o) == 1);

    p_legal_pattern_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(diff_w) <= 1);

    p_full_phase_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (ring_o == '1) == phase_o[WIDTH]);

    p_empty_phase_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (ring_o == '0) == phase_o[0]);
endmodule

bind twisted_ring_counter trc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .ring_o  (ring_o),
    .phase_o (phase_o)
);

// File: tb/twisted_ring_counter_tb.sv
module twisted_ring_counter_tb;
    localparam int unsigned W  = 4;
    localparam int unsigned NP = 2 * W;

    logic          clk = 1'b0;
    logic          rst;
    logic          en;
    logic [W-1:0]  ring;
    logic [NP-1:0] phase;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    twisted_ring_counter #(.WIDTH(W)) u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .en_i    (en),
        .ring_o  (ring),
        .phase_o (phase)
    );

    // {rst, en, expected ring[3:0], expected phase index[2:0]}
    localparam logic [8:0] VEC [16] = '{
        {1'b1, 1'b1, 4'b0000, 3'd0},  // R1 reset
        {1'b0, 1'b1, 4'b1000, 3'd1},  // R2
        {1'b0, 1'b1, 4'b1100, 3'd2},
        {1'b0, 1'b0, 4'b1100, 3'd2},  // R3 hold
        {1'b0, 1'b1, 4'b1110, 3'd3},
        {1'b0, 1'b1, 4'b1111, 3'd4},  // R7 all ones
        {1'b0, 1'b0, 4'b1111, 3'd4},  // R3 hold
        {1'b0, 1'b1, 4'b0111, 3'd5},
        {1'b0, 1'b1, 4'b0011, 3'd6},
        {1'b0, 1'b1, 4'b0001, 3'd7},
        {1'b0, 1'b1, 4'b0000, 3'd0},  // R4 wrap
        {1'b0, 1'b1, 4'b1000, 3'd1},
        {1'b1, 1'b1, 4'b0000, 3'd0},  // R1 reset beats enable
        {1'b0, 1'b1, 4'b1000, 3'd1},
        {1'b0, 1'b1, 4'b1100, 3'd2},
        {1'b1, 1'b0, 4'b0000, 3'd0}   // R1
    };

    task automatic check(input string req, input logic [NP-1:0] act,
                         input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic e);
        @(negedge clk);
        rst = r;
        en  = e;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [W-1:0] model;
        int           zero_at;
        rst = 1'b1;
        en  = 1'b0;
        step(1'b1, 1'b0);
        check("R1 reset ring", NP'(ring), NP'(0));
        check("R1 reset phase", phase, NP'(1));

        // Table walk
        for (int i = 0; i < 16; i++) begin
            step(VEC[i][8], VEC[i][7]);
            check("R2/R3 ring vs table", NP'(ring), NP'(VEC[i][6:3]));
            check("R5 phase vs table", phase, NP'(1) << VEC[i][2:0]);
        end

        // Directed: three full cycles against a shift model
        step(1'b1, 1'b0);
        model   = '0;
        zero_at = -1;
        for (int s = 1; s <= 3 * NP; s++) begin
            step(1'b0, 1'b1);
            model = {~model[0], model[W-1:1]};
            check("R2 model ring", NP'(ring), NP'(model));
            check("R5 phase index", phase, NP'(1) << (s % NP));
            check("R7 full/empty flags",
                  NP'({phase[W], phase[0]}),
                  NP'({ring == '1, ring == '0}));
            if (zero_at < 0 && ring == '0) zero_at = s;
        end
        check("R4 first return to zero", NP'(zero_at), NP'(NP));

        // Directed: long idle stretch in the middle of the cycle
        step(1'b0, 1'b1);
        for (int h = 0; h < 5; h++) begin
            step(1'b0, 1'b0);
            check("R3 idle hold", NP'(ring), NP'(4'b1000));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule